// File: doc/BRIEF.md
# Remapping Enable Command Controller

The block switches device DMA address remapping on and off at a safe point. Software writes a command register whose top bit asks for remapping to be on or off. The block never applies that request at once. It closes the request path, waits until every DMA request it has already passed onward has reported completion, and only then changes the applied enable state. The applied state is shown on a separate read-only status register and on the `remap_en` output.

Requests pass straight through a valid/ready handshake to the downstream side. Each one carries a tag, `fwd_remap`, that tells the downstream logic whether to translate it. The applied state cannot change while any accepted request is still outstanding. Because of this, a request's tag stays valid from acceptance to completion, and no transaction is ever partly remapped.

Address translation, table walks and fault reporting belong to other blocks.

Top module: `remap_enable_ctrl`

## Requirements
- R1: After reset, `remap_en` is 0, the status register reads 0, no command is pending and the in-flight count is 0, so `req_ready` equals `fwd_ready`.
- R2: Only a write to offset `CMD_OFS` with `reg_wr_en` high is a command, and only bit 31 of its data counts (1 = remap on, 0 = remap off). Writes to any other offset, including the status offset, change nothing.
- R3: A read of the command offset always returns 32'h0, whatever was written there.
- R4: A read of the status offset `STS_OFS` returns the applied enable state in bit 31 and zeros in bits 30..0. A read of any other offset returns 0, and so does a cycle with no read.
- R5: The clock edge that samples a command asking for a state different from the applied one starts a drain. From the next cycle until the new state is applied, `req_ready` and `fwd_valid` stay low.
- R6: During a drain, the first clock edge at which the in-flight count is 0 changes `remap_en` and the status bit together. The request path reopens in the following cycle.
- R7: The in-flight count rises by one for each accepted request (`req_valid && req_ready`) and falls by one for each `cpl_pulse`. Both together leave it unchanged. A `cpl_pulse` at count 0 is ignored. At count `MAX_INFLIGHT`, `req_ready` is held low.
- R8: A command that asks for the state already applied is finished at once. It starts no drain, and `req_ready` stays high when `fwd_ready` is high.
- R9: `fwd_remap` equals `remap_en`, and `remap_en` does not change on any edge at which the in-flight count is nonzero, so a request's tag holds until it completes.
- R10: A command written during a drain is held and applied after the current command finishes, with a drain of its own if needed. If several arrive, the last one wins.
- R11: With `RD_LATENCY` = 1, read data appears in the cycle after the read. With `RD_LATENCY` = 0, it appears combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Register write offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | ADDR_W | Register read offset |
| reg_rd_data | output | 32 | Register read data |
| req_valid | input | 1 | Upstream DMA request valid |
| req_ready | output | 1 | Upstream DMA request ready |
| fwd_valid | output | 1 | Downstream request valid |
| fwd_ready | input | 1 | Downstream request ready |
| fwd_remap | output | 1 | Tag: request is to be remapped |
| cpl_pulse | input | 1 | One outstanding request completed |
| remap_en | output | 1 | Applied remapping enable state |

## Verification
The bench builds the block with `MAX_INFLIGHT` = 3 and `RD_LATENCY` = 1. The small limit makes a full in-flight window reachable in a few cycles, so the stall at the limit, accept and completion in the same cycle, and a drain from a full window all come up often in directed and random traffic. The registered read path tests the one-cycle read timing against status changes that happen at drain completion. Held commands written during a drain, and same-state commands, come up both in directed order and at random.

// File: rtl/remap_pkg.sv
package remap_pkg;

   // Sequencer states: open for traffic, or draining before applying.
   typedef enum logic {
      SEQ_OPEN  = 1'b0,
      SEQ_DRAIN = 1'b1
   } seq_state_t;

   // Bit of command/status data that carries the enable value.
   localparam int ENABLE_BIT = 31;
   localparam int REG_W      = 32;

endpackage

// File: rtl/remap_inflight_ctr.sv
module remap_inflight_ctr #(
   parameter int MAX_INFLIGHT = 16,
   localparam int CNT_W = $clog2(MAX_INFLIGHT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);

   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_INFLIGHT);

   generate
      if (MAX_INFLIGHT < 1) begin : g_bad_limit
         $error("remap_inflight_ctr: MAX_INFLIGHT must be at least 1");
      end
   endgenerate

   logic             dec_ok;
   logic [CNT_W-1:0] count_q;

   // A completion with nothing outstanding is dropped.
   assign dec_ok = dec && (count_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (inc && !dec_ok) begin
         count_q <= count_q + 1'b1;
      end else if (!inc && dec_ok) begin
         count_q <= count_q - 1'b1;
      end
   end

   assign count = count_q;
   assign full  = (count_q == LIMIT);
   assign empty = (count_q == '0);

endmodule

// File: rtl/remap_cmd_seq.sv
module remap_cmd_seq
   import remap_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_wr,
   input  logic cmd_val,
   input  logic drained,
   output logic applied_en,
   output logic draining,
   output logic held_v
);

   seq_state_t state_q;
   logic       en_q;
   logic       target_q;
   logic       held_q;
   logic       held_v_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SEQ_OPEN;
         en_q     <= 1'b0;
         target_q <= 1'b0;
         held_q   <= 1'b0;
         held_v_q <= 1'b0;
      end else begin
         unique case (state_q)
            SEQ_OPEN: begin
               if (held_v_q) begin
                  // The held command goes first; a fresh write takes its slot.
                  held_v_q <= 1'b0;
                  if (held_q != en_q) begin
                     target_q <= held_q;
                     state_q  <= SEQ_DRAIN;
                  end
                  if (cmd_wr) begin
                     held_q   <= cmd_val;
                     held_v_q <= 1'b1;
                  end
               end else if (cmd_wr && (cmd_val != en_q)) begin
                  target_q <= cmd_val;
                  state_q  <= SEQ_DRAIN;
               end
            end
            SEQ_DRAIN: begin
               if (drained) begin
                  en_q    <= target_q;
                  state_q <= SEQ_OPEN;
               end
               if (cmd_wr) begin
                  held_q   <= cmd_val;
                  held_v_q <= 1'b1;
               end
            end
            default: state_q <= SEQ_OPEN;
         endcase
      end
   end

   assign applied_en = en_q;
   assign draining   = (state_q == SEQ_DRAIN);
   assign held_v     = held_v_q;

endmodule

// File: rtl/remap_regs.sv
module remap_regs
   import remap_pkg::*;
#(
   parameter int                ADDR_W     = 4,
   parameter logic [ADDR_W-1:0] CMD_OFS    = '0,
   parameter logic [ADDR_W-1:0] STS_OFS    = ADDR_W'(4),
   parameter int                RD_LATENCY = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              status_en,
   output logic [REG_W-1:0]  rd_data,
   output logic              cmd_wr,
   output logic              cmd_val
);

   generate
      if (CMD_OFS == STS_OFS) begin : g_bad_map
         $error("remap_regs: command and status offsets must differ");
      end
      if (RD_LATENCY != 0 && RD_LATENCY != 1) begin : g_bad_lat
         $error("remap_regs: RD_LATENCY must be 0 or 1");
      end
   endgenerate

   // Command decode: only the enable bit is meaningful.
   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data[ENABLE_BIT-1:0];
   assign cmd_wr  = wr_en && (wr_addr == CMD_OFS);
   assign cmd_val = wr_data[ENABLE_BIT];

   // Command offset always reads as zero; status carries applied state.
   logic [REG_W-1:0] rd_value;
   always_comb begin
      rd_value = '0;
      if (rd_en && (rd_addr == STS_OFS)) begin
         rd_value[ENABLE_BIT] = status_en;
      end
   end

   generate
      if (RD_LATENCY == 0) begin : g_rd_comb
         assign rd_data = rd_value;
      end else begin : g_rd_reg
         logic [REG_W-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_value;
         end
         assign rd_data = rd_q;
      end
   endgenerate

endmodule

// File: rtl/remap_enable_ctrl.sv
module remap_enable_ctrl #(
   parameter int                MAX_INFLIGHT = 16,
   parameter int                ADDR_W       = 4,
   parameter logic [ADDR_W-1:0] CMD_OFS      = '0,
   parameter logic [ADDR_W-1:0] STS_OFS      = ADDR_W'(4),
   parameter int                RD_LATENCY   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_wr_addr,
   input  logic [31:0]       reg_wr_data,
   input  logic              reg_rd_en,
   input  logic [ADDR_W-1:0] reg_rd_addr,
   output logic [31:0]       reg_rd_data,
   input  logic              req_valid,
   output logic              req_ready,
   output logic              fwd_valid,
   input  logic              fwd_ready,
   output logic              fwd_remap,
   input  logic              cpl_pulse,
   output logic              remap_en
);

   localparam int CNT_W = $clog2(MAX_INFLIGHT + 1);

   logic             cmd_wr;
   logic             cmd_val;
   logic             applied_en;
   logic             draining;
   logic             held_v;
   logic [CNT_W-1:0] inflight;
   logic             win_full;
   logic             win_empty;
   logic             gate_open;
   logic             accept;

   remap_regs #(
      .ADDR_W     (ADDR_W),
      .CMD_OFS    (CMD_OFS),
      .STS_OFS    (STS_OFS),
      .RD_LATENCY (RD_LATENCY)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr_en),
      .wr_addr   (reg_wr_addr),
      .wr_data   (reg_wr_data),
      .rd_en     (reg_rd_en),
      .rd_addr   (reg_rd_addr),
      .status_en (applied_en),
      .rd_data   (reg_rd_data),
      .cmd_wr    (cmd_wr),
      .cmd_val   (cmd_val)
   );

   remap_cmd_seq seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_wr     (cmd_wr),
      .cmd_val    (cmd_val),
      .drained    (win_empty),
      .applied_en (applied_en),
      .draining   (draining),
      .held_v     (held_v)
   );

   remap_inflight_ctr #(
      .MAX_INFLIGHT (MAX_INFLIGHT)
   ) ctr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (accept),
      .dec   (cpl_pulse),
      .count (inflight),
      .full  (win_full),
      .empty (win_empty)
   );

   assign gate_open = !draining && !win_full;
   assign req_ready = fwd_ready && gate_open;
   assign fwd_valid = req_valid && gate_open;
   assign accept    = req_valid && req_ready;
   assign fwd_remap = applied_en;
   assign remap_en  = applied_en;

endmodule

// File: rtl/remap_enable_ctrl_chk.sv
module remap_enable_ctrl_chk #(
   parameter int MAX_INFLIGHT = 16,
   localparam int CNT_W = $clog2(MAX_INFLIGHT + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             remap_en,
   input logic             draining,
   input logic             held_v,
   input logic             cmd_wr,
   input logic             cmd_val,
   input logic [CNT_W-1:0] inflight,
   input logic             req_valid,
   input logic             req_ready,
   input logic             fwd_valid,
   input logic             cpl_pulse
);

   // R5
   gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      draining |-> (!req_ready && !fwd_valid));

   // R6
   drain_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (draining && inflight == '0) |=> !draining);

   // R7
   window_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= CNT_W'(MAX_INFLIGHT));

   // R7
   count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !cpl_pulse) |=> (inflight == $past(inflight) + 1'b1));

   // R8
   same_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!draining && !held_v && cmd_wr && cmd_val == remap_en) |=> !draining);

   // R9
   tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inflight != '0) |=> $stable(remap_en));

endmodule

bind remap_enable_ctrl remap_enable_ctrl_chk #(
   .MAX_INFLIGHT (MAX_INFLIGHT)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .remap_en  (remap_en),
   .draining  (draining),
   .held_v    (held_v),
   .cmd_wr    (cmd_wr),
   .cmd_val   (cmd_val),
   .inflight  (inflight),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .fwd_valid (fwd_valid),
   .cpl_pulse (cpl_pulse)
);

// File: tb/remap_enable_ctrl_test.sv
`timescale 1ns/1ps
module remap_enable_ctrl_test;

   localparam int         MAXW = 3;
   localparam logic [3:0] CMD  = 4'h0;
   localparam logic [3:0] STS  = 4'h4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [3:0]  reg_wr_addr = '0;
   logic [31:0] reg_wr_data = '0;
   logic        reg_rd_en = 1'b0;
   logic [3:0]  reg_rd_addr = '0;
   logic [31:0] reg_rd_data;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        fwd_valid;
   logic        fwd_ready = 1'b0;
   logic        fwd_remap;
   logic        cpl_pulse = 1'b0;
   logic        remap_en;

   always #5 clk = ~clk;

   remap_enable_ctrl #(
      .MAX_INFLIGHT (MAXW),
      .ADDR_W       (4),
      .CMD_OFS      (CMD),
      .STS_OFS      (STS),
      .RD_LATENCY   (1)
   ) uut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
      .req_valid(req_valid), .req_ready(req_ready), .fwd_valid(fwd_valid),
      .fwd_ready(fwd_ready), .fwd_remap(fwd_remap), .cpl_pulse(cpl_pulse),
      .remap_en(remap_en)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   // Behavioural reference state.
   bit          m_en, m_drain, m_tgt, m_held, m_heldv;
   int          m_cnt;
   logic [31:0] m_rd;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_en = 0; m_drain = 0; m_tgt = 0; m_held = 0; m_heldv = 0;
      m_cnt = 0; m_rd = '0;
   endtask

   // One cycle: drive at negedge, compare, update model at the edge.
   task automatic step(input bit rv, input bit fr, input bit cp,
                       input bit we, input logic [3:0] wa, input logic [31:0] wd,
                       input bit re, input logic [3:0] ra);
      bit gate, acc, dec, wv;
      req_valid = rv; fwd_ready = fr; cpl_pulse = cp;
      reg_wr_en = we; reg_wr_addr = wa; reg_wr_data = wd;
      reg_rd_en = re; reg_rd_addr = ra;
      #1;
      gate = !m_drain && (m_cnt < MAXW);
      chk("R5 req_ready", {31'b0, req_ready}, {31'b0, fr && gate});
      chk("R5 fwd_valid", {31'b0, fwd_valid}, {31'b0, rv && gate});
      chk("R9 fwd_remap", {31'b0, fwd_remap}, {31'b0, m_en});
      chk("R6 remap_en",  {31'b0, remap_en},  {31'b0, m_en});
      chk("R4 rd_data",   reg_rd_data, m_rd);
      @(posedge clk);
      acc = rv && fr && gate;
      dec = cp && (m_cnt > 0);
      wv  = we && (wa == CMD);
      m_rd = (re && ra == STS) ? {m_en, 31'b0} : 32'h0;
      if (m_drain) begin
         if (m_cnt == 0) begin m_en = m_tgt; m_drain = 0; end
         if (wv) begin m_held = wd[31]; m_heldv = 1; end
      end else if (m_heldv) begin
         m_heldv = 0;
         if (m_held != m_en) begin m_tgt = m_held; m_drain = 1; end
         if (wv) begin m_held = wd[31]; m_heldv = 1; end
      end else if (wv && wd[31] != m_en) begin
         m_tgt = wd[31]; m_drain = 1;
      end
      m_cnt = m_cnt + int'(acc) - int'(dec);
      @(negedge clk);
   endtask

   task automatic idle();
      step(0, 1, 0, 0, CMD, 0, 0, CMD);
   endtask
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      step(0, 1, 0, 1, a, d, 0, CMD);
   endtask
   task automatic rd(input logic [3:0] a);
      step(0, 1, 0, 0, CMD, 0, 1, a);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      fwd_ready = 1'b1;
      #1;
      // R1 reset state
      chk("R1 remap_en", {31'b0, remap_en}, 32'h0);
      chk("R1 req_ready", {31'b0, req_ready}, 32'h1);
      chk("R1 rd_data", reg_rd_data, 32'h0);
      @(negedge clk);

      rd(STS);
      chk("R11 status read after one cycle", reg_rd_data, 32'h0);

      // Enable with an empty window.
      wr(CMD, 32'h8000_0000);
      idle();
      chk("R6 enable applied", {31'b0, remap_en}, 32'h1);
      rd(STS);
      chk("R4 status bit 31", reg_rd_data, 32'h8000_0000);
      rd(CMD);
      chk("R3 command reads zero", reg_rd_data, 32'h0);

      // Write to status offset is not a command.
      wr(STS, 32'h0);
      idle(); idle();
      chk("R2 status offset write ignored", {31'b0, remap_en}, 32'h1);

      // Same-state command: no stall.
      wr(CMD, 32'hFFFF_FFFF);
      chk("R8 no stall on same state", {31'b0, req_ready}, 32'h1);

      // Two in flight, then disable; enable written during drain.
      step(1, 1, 0, 0, CMD, 0, 0, CMD);
      step(1, 1, 0, 0, CMD, 0, 0, CMD);
      step(0, 1, 0, 1, CMD, 32'h7FFF_FFFF, 0, CMD);
      chk("R5 gate closed during drain", {31'b0, req_ready}, 32'h0);
      chk("R9 enable held while in flight", {31'b0, remap_en}, 32'h1);
      wr(CMD, 32'h8000_0000);
      step(0, 1, 1, 0, CMD, 0, 0, CMD);
      step(0, 1, 1, 0, CMD, 0, 0, CMD);
      idle();
      chk("R6 disable applied after drain", {31'b0, remap_en}, 32'h0);
      idle(); idle();
      chk("R10 held enable applied", {31'b0, remap_en}, 32'h1);

      // Fill the window.
      for (int i = 0; i < 3; i++) step(1, 1, 0, 0, CMD, 0, 0, CMD);
      chk("R7 full window stalls", {31'b0, req_ready}, 32'h0);
      step(1, 1, 1, 0, CMD, 0, 0, CMD);
      step(1, 1, 1, 0, CMD, 0, 0, CMD);
      chk("R7 accept with completion keeps count", {31'b0, req_ready}, 32'h1);
      step(0, 1, 1, 0, CMD, 0, 0, CMD);
      step(0, 1, 1, 0, CMD, 0, 0, CMD);
      step(0, 1, 1, 0, CMD, 0, 0, CMD);   // at zero: ignored
      for (int i = 0; i < 3; i++) step(1, 1, 0, 0, CMD, 0, 0, CMD);
      chk("R7 extra completion ignored", {31'b0, req_ready}, 32'h0);
      for (int i = 0; i < 3; i++) step(0, 1, 1, 0, CMD, 0, 0, CMD);

      // Mixed traffic.
      for (int i = 0; i < 4000; i++) begin
         bit rv, fr, cp, we, re;
         logic [3:0] wa, ra;
         rv = ($urandom % 3) != 0;
         fr = ($urandom % 4) != 0;
         cp = ($urandom % 3) == 0;
         we = ($urandom % 12) == 0;
         wa = (($urandom % 4) == 0) ? STS : CMD;
         re = ($urandom % 3) == 0;
         ra = (($urandom % 3) == 0) ? CMD : STS;
         step(rv, fr, cp, we, wa, $urandom, re, ra);
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule